// File: doc/BRIEF.md
# Program Sequencer with Interrupt Stack

This block steers program flow for a small 8-bit microcontroller. It holds the instruction address and a circular return stack, and it acts on four flow operations: jump, call, return and return-from-interrupt. Each of them may run always or only when a test on the zero or carry flag holds. It also handles an interrupt-enable control operation. Every instruction occupies two clock cycles. All state changes happen on the rising edge that closes the second cycle, which is the instruction boundary.

An interrupt request is seen only at that boundary and only while interrupts are enabled. When it is taken, the instruction in progress is dropped. Its own address and the live zero and carry flags are saved as one stack entry, and execution moves to the vector at the top of the address space. The return-from-interrupt operation brings back the saved address and flags and turns interrupts on again. The flags come back on dedicated outputs, marked by a one-cycle load strobe.

Top module: `prog_sequencer`

## Requirements
- R1: While reset is held and straight after it, `pc_o` is 0, `irq_ack_o`, `flag_load_o`, `zero_o`, `carry_o` and `stack_ovf_o` are 0, and interrupts are disabled, so a request does not divert the program.
- R2: `pc_o` changes only on every second rising edge after reset, at the instruction boundary. An instruction that is neither a taken flow operation nor an interrupt advances it by one, and 0xFF wraps to 0x00.
- R3: A flow instruction has bits 15:13 = 100, with bits 9:8 giving the operation: 00 jump, 01 call, 10 return, 11 return-from-interrupt. A taken jump loads bits 7:0 into `pc_o`.
- R4: Bit 12 = 0 makes a flow instruction unconditional. Bit 12 = 1 tests bits 11:10: 00 zero set, 01 zero clear, 10 carry set, 11 carry clear. A failed test advances `pc_o` by one and leaves the stack and flag outputs untouched.
- R5: A taken call stores the address after the call and loads bits 7:0. A taken return loads the most recent stored address and leaves `zero_o` and `carry_o` unchanged.
- R6: An instruction with bits 15:13 = 111 sets the interrupt enable to bit 0 and advances `pc_o` by one. The new setting applies from the next boundary onward.
- R7: When `irq_i` is high at a boundary with interrupts enabled, the current instruction is dropped. Its address and the current zero and carry flags are stored, `pc_o` becomes 0xFF, and `irq_ack_o` is high for exactly that one cycle. Interrupts are then disabled, so further requests are ignored.
- R8: A taken return-from-interrupt loads the stored address, drives the stored flags onto `zero_o` and `carry_o`, pulses `flag_load_o` for one cycle, and enables interrupts again.
- R9: The stack holds 31 entries in last-in-first-out order. A 32nd store overwrites the oldest entry and sets `stack_ovf_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word for the current instruction |
| zero_i | input | 1 | Current zero flag |
| carry_i | input | 1 | Current carry flag |
| irq_i | input | 1 | Interrupt request |
| pc_o | output | 8 | Instruction address |
| zero_o | output | 1 | Zero flag restored by return-from-interrupt |
| carry_o | output | 1 | Carry flag restored by return-from-interrupt |
| flag_load_o | output | 1 | One-cycle strobe marking restored flags |
| irq_ack_o | output | 1 | One-cycle interrupt acknowledge |
| stack_ovf_o | output | 1 | Sticky stack overflow indication |

## Verification
The inputs for an instruction are applied on a falling edge. All of its results (address, acknowledge, flag strobe, restored flags, overflow) come from the second rising edge after that, and the two strobes last only one cycle. The driver records each expectation with a due count of two rising edges past the moment it applied the inputs. The monitor counts rising edges and compares the head of the queue 2 ns after the edge whose count matches. Each result is therefore read inside the single cycle in which a strobe is valid, and before the next instruction can move the address.

// File: rtl/ps_pkg.sv
`timescale 1ns/1ps
package ps_pkg;
    typedef enum logic [1:0] {
        FL_JUMP = 2'b00,
        FL_CALL = 2'b01,
        FL_RET  = 2'b10,
        FL_RETI = 2'b11
    } flow_op_e;

    localparam logic [2:0] CLASS_FLOW  = 3'b100;
    localparam logic [2:0] CLASS_IECTL = 3'b111;

    typedef struct packed {
        logic     is_flow;
        flow_op_e op;
        logic     take;
        logic     is_iectl;
        logic     ie_val;
    } dec_t;
endpackage

// File: rtl/ps_decode.sv
`timescale 1ns/1ps
module ps_decode
    import ps_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic [15:0]     instr_i,
    input  logic            zero_i,
    input  logic            carry_i,
    output dec_t            dec_o,
    output logic [PC_W-1:0] target_o
);
    logic cond_hit;

    // flag test selected by bits 11:10
    always_comb begin
        unique case (instr_i[11:10])
            2'b00:   cond_hit = zero_i;
            2'b01:   cond_hit = ~zero_i;
            2'b10:   cond_hit = carry_i;
            default: cond_hit = ~carry_i;
        endcase
    end

    always_comb begin
        dec_o.is_flow  = (instr_i[15:13] == CLASS_FLOW);
        dec_o.op       = flow_op_e'(instr_i[9:8]);
        dec_o.take     = ~instr_i[12] | cond_hit;
        dec_o.is_iectl = (instr_i[15:13] == CLASS_IECTL);
        dec_o.ie_val   = instr_i[0];
        target_o       = instr_i[PC_W-1:0];
    end
endmodule

// File: rtl/ps_stack.sv
`timescale 1ns/1ps
module ps_stack #(
    parameter int ENTRY_W = 10,
    parameter int DEPTH   = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [ENTRY_W-1:0] data_i,
    output logic [ENTRY_W-1:0] top_o,
    output logic               ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } stk_t;

    stk_t               st_d, st_q;
    logic [ENTRY_W-1:0] mem_d [DEPTH];
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_LAST : p - 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (push_i) begin
            mem_d[st_q.ptr] = data_i;
            st_d.ptr        = ptr_inc(st_q.ptr);
            if (st_q.cnt == CNT_FULL) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (pop_i) begin
            st_d.ptr = ptr_dec(st_q.ptr);
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign top_o = mem_q[ptr_dec(st_q.ptr)];
    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/prog_sequencer.sv
`timescale 1ns/1ps
module prog_sequencer
    import ps_pkg::*;
#(
    parameter int              PC_W        = 8,
    parameter int              STACK_DEPTH = 31,
    parameter logic [PC_W-1:0] VECTOR      = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     instr_i,
    input  logic            zero_i,
    input  logic            carry_i,
    input  logic            irq_i,
    output logic [PC_W-1:0] pc_o,
    output logic            zero_o,
    output logic            carry_o,
    output logic            flag_load_o,
    output logic            irq_ack_o,
    output logic            stack_ovf_o
);
    localparam int ENTRY_W = PC_W + 2;

    typedef struct packed {
        logic            phase;
        logic [PC_W-1:0] pc;
        logic            ie;
        logic            ack;
        logic            fload;
        logic            z;
        logic            c;
    } seq_t;

    seq_t               s_d, s_q;
    dec_t               dec;
    logic [PC_W-1:0]    target;
    logic [PC_W-1:0]    pc_inc;
    logic               push, pop;
    logic [ENTRY_W-1:0] push_data, top_entry;

    ps_decode #(.PC_W(PC_W)) u_decode (
        .instr_i  (instr_i),
        .zero_i   (zero_i),
        .carry_i  (carry_i),
        .dec_o    (dec),
        .target_o (target)
    );

    ps_stack #(.ENTRY_W(ENTRY_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .pop_i  (pop),
        .data_i (push_data),
        .top_o  (top_entry),
        .ovf_o  (stack_ovf_o)
    );

    assign pc_inc = s_q.pc + 1'b1;

    // stack entry layout: {address, carry, zero}
    always_comb begin
        s_d       = s_q;
        s_d.phase = ~s_q.phase;
        s_d.ack   = 1'b0;
        s_d.fload = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = {s_q.pc, carry_i, zero_i};
        if (s_q.phase) begin
            if (irq_i && s_q.ie) begin
                push     = 1'b1;
                s_d.pc   = VECTOR;
                s_d.ie   = 1'b0;
                s_d.ack  = 1'b1;
            end else if (dec.is_flow && dec.take) begin
                unique case (dec.op)
                    FL_JUMP: s_d.pc = target;
                    FL_CALL: begin
                        push      = 1'b1;
                        push_data = {pc_inc, carry_i, zero_i};
                        s_d.pc    = target;
                    end
                    FL_RET: begin
                        pop    = 1'b1;
                        s_d.pc = top_entry[ENTRY_W-1:2];
                    end
                    default: begin
                        pop       = 1'b1;
                        s_d.pc    = top_entry[ENTRY_W-1:2];
                        s_d.c     = top_entry[1];
                        s_d.z     = top_entry[0];
                        s_d.fload = 1'b1;
                        s_d.ie    = 1'b1;
                    end
                endcase
            end else begin
                s_d.pc = pc_inc;
                if (dec.is_iectl) begin
                    s_d.ie = dec.ie_val;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o        = s_q.pc;
    assign zero_o      = s_q.z;
    assign carry_o     = s_q.c;
    assign flag_load_o = s_q.fload;
    assign irq_ack_o   = s_q.ack;
endmodule

// File: rtl/ps_checker.sv
`timescale 1ns/1ps
module ps_checker #(
    parameter int              PC_W   = 8,
    parameter logic [PC_W-1:0] VECTOR = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc_o,
    input logic            irq_ack_o,
    input logic            flag_load_o,
    input logic            stack_ovf_o
);
    AST_PC_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |=> $stable(pc_o));                             // R2
    AST_ACK_AT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> (pc_o == VECTOR));                                // R7
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> !irq_ack_o);                                      // R7
    AST_FLOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load_o |=> !flag_load_o);                                  // R8
    AST_ACK_FLOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack_o && flag_load_o));                                   // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf_o |=> stack_ovf_o);                                   // R9
endmodule

bind prog_sequencer ps_checker #(.PC_W(PC_W), .VECTOR(VECTOR)) u_ps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_o        (pc_o),
    .irq_ack_o   (irq_ack_o),
    .flag_load_o (flag_load_o),
    .stack_ovf_o (stack_ovf_o)
);

// File: tb/prog_sequencer_bench.sv
`timescale 1ns/1ps
module prog_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic        zero = 1'b0, carry = 1'b0, irq = 1'b0;
    logic [7:0]  pc_o;
    logic        zero_o, carry_o, flag_load_o, irq_ack_o, stack_ovf_o;

    prog_sequencer u_prog_sequencer (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .zero_i(zero), .carry_i(carry),
        .irq_i(irq), .pc_o(pc_o), .zero_o(zero_o), .carry_o(carry_o),
        .flag_load_o(flag_load_o), .irq_ack_o(irq_ack_o), .stack_ovf_o(stack_ovf_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_tests = 0, n_fail = 0, pcount = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [12:0] exp;
        string       req;
    } item_t;
    item_t sbq[$];

    // reference model state
    logic [7:0] m_pc = '0;
    bit         m_ie = 1'b0;
    logic       m_z = 1'b0, m_c = 1'b0, m_ovf = 1'b0;
    logic [9:0] m_stk[$];

    localparam logic [15:0] NOP = 16'h0000;

    function automatic logic [15:0] fl(input logic [1:0] op, input logic cnd,
                                       input logic [1:0] cc, input logic [7:0] t);
        return {3'b100, cnd, cc, op, t};
    endfunction

    function automatic logic [15:0] iectl(input logic v);
        return {3'b111, 12'h000, v};
    endfunction

    task automatic m_push(input logic [9:0] e);
        if (m_stk.size() == 31) begin
            void'(m_stk.pop_front());
            m_ovf = 1'b1;
        end
        m_stk.push_back(e);
    endtask

    task automatic step(input logic [15:0] ins, input logic z, input logic c,
                        input logic irq_v, input string req);
        logic       ack = 1'b0, fld = 1'b0, take;
        logic [7:0] nxt;
        logic [9:0] e;
        instr = ins; zero = z; carry = c; irq = irq_v;
        nxt = m_pc + 8'd1;
        if (irq_v && m_ie) begin
            m_push({m_pc, c, z});
            nxt = 8'hFF; m_ie = 1'b0; ack = 1'b1;
        end else if (ins[15:13] == 3'b100) begin
            case (ins[11:10])
                2'b00: take = z;
                2'b01: take = !z;
                2'b10: take = c;
                default: take = !c;
            endcase
            if (!ins[12]) take = 1'b1;
            if (take) begin
                case (ins[9:8])
                    2'b00: nxt = ins[7:0];
                    2'b01: begin m_push({m_pc + 8'd1, c, z}); nxt = ins[7:0]; end
                    2'b10: begin e = m_stk.pop_back(); nxt = e[9:2]; end
                    default: begin
                        e = m_stk.pop_back(); nxt = e[9:2];
                        m_c = e[1]; m_z = e[0]; fld = 1'b1; m_ie = 1'b1;
                    end
                endcase
            end
        end else if (ins[15:13] == 3'b111) begin
            m_ie = ins[0];
        end
        m_pc = nxt;
        sbq.push_back('{pcount + 2, {m_pc, ack, fld, m_z, m_c, m_ovf}, req});
        repeat (2) @(negedge clk);
    endtask

    // monitor: compare each expectation at its due edge
    initial begin
        forever begin
            item_t it;
            logic [12:0] act;
            @(posedge clk);
            #2;
            pcount++;
            if (sbq.size() > 0 && sbq[0].due == pcount) begin
                it  = sbq.pop_front();
                act = {pc_o, irq_ack_o, flag_load_o, zero_o, carry_o, stack_ovf_o};
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: {pc,ack,fload,z,c,ovf} actual=%h expected=%h",
                             it.req, act, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;   // R1 reset state
        if ({pc_o, irq_ack_o, flag_load_o, zero_o, carry_o, stack_ovf_o} !== 13'h0) begin
            n_fail++;
            $display("FAIL R1: actual=%h expected=0000",
                     {pc_o, irq_ack_o, flag_load_o, zero_o, carry_o, stack_ovf_o});
        end
        rst_n = 1'b1;
        step(NOP, 0, 0, 1, "R1 irq ignored after reset");
        step(NOP, 0, 0, 0, "R2 advance");
        step(fl(2'b00, 0, 2'b00, 8'hFE), 0, 0, 0, "R3 jump");
        step(NOP, 0, 0, 0, "R2 advance to FF");
        step(NOP, 0, 0, 0, "R2 wrap to 00");
        // R4 every condition, true then false
        for (int cc = 0; cc < 4; cc++) begin
            logic f = (cc == 0 || cc == 2);
            step(fl(2'b00, 1, 2'(cc), 8'(8'h20 + cc)), f, f, 0, "R4 cond true");
            step(fl(2'b00, 1, 2'(cc), 8'h40), !f, !f, 0, "R4 cond false");
        end
        step(fl(2'b01, 1, 2'b10, 8'h70), 0, 0, 0, "R4 call skipped");
        step(fl(2'b01, 0, 2'b00, 8'h50), 0, 0, 0, "R5 call");
        step(fl(2'b01, 0, 2'b00, 8'h60), 1, 1, 0, "R5 nested call");
        step(fl(2'b10, 0, 2'b00, 8'h00), 0, 0, 0, "R5 return inner");
        step(fl(2'b10, 1, 2'b01, 8'h00), 0, 0, 0, "R5 conditional return");
        step(iectl(1'b1), 0, 0, 1, "R6 enable, request not yet seen");
        step(fl(2'b00, 0, 2'b00, 8'h90), 1, 0, 1, "R7 interrupt entry");
        step(NOP, 0, 0, 1, "R7 request ignored inside handler");
        step(fl(2'b11, 1, 2'b00, 8'h00), 0, 1, 0, "R4 reti skipped");
        step(fl(2'b11, 0, 2'b00, 8'h00), 0, 1, 0, "R8 reti restores flags");
        step(NOP, 0, 1, 1, "R8 re-enabled interrupt");
        step(fl(2'b01, 0, 2'b00, 8'hA0), 0, 0, 0, "R5 call in handler");
        step(fl(2'b10, 0, 2'b00, 8'h00), 0, 0, 0, "R5 return keeps flags");
        step(fl(2'b11, 0, 2'b00, 8'h00), 1, 1, 0, "R8 reti second");
        step(iectl(1'b0), 0, 0, 0, "R6 disable");
        step(NOP, 0, 0, 1, "R6 request ignored when disabled");
        for (int i = 0; i < 32; i++) begin
            step(fl(2'b01, 0, 2'b00, 8'(i * 5 + 10)), i[0], 0, 0, "R9 fill stack");
        end
        for (int i = 0; i < 31; i++) begin
            step(fl(2'b10, 0, 2'b00, 8'h00), 0, 0, 0, "R9 unwind stack");
        end
        instr = NOP; irq = 1'b0;
        repeat (4) @(negedge clk);
        n_tests++;
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL R2: pending actual=%0d expected=0", sbq.size());
        end
        finish_run();
    end
endmodule